// File: doc/BRIEF.md
# Clock Frequency Measurement Counter

This block measures how fast a test clock runs by counting its edges over a window of reference ticks. The reference tick is the bus clock divided by four. It advances only while the reference-gate input is high. A host starts a run with one control write that carries a tick count and a start flag. It then polls a status word until the done flag is set, and reads the captured edge count from the same word. The host turns that count into a rate itself.

A control write with the start flag clear stops the window and loads the tick count. The host waits for done to read low before it starts a new run. The test-clock counter is cleared only by logic clocked by the test clock. A test clock that has stopped therefore leaves the old count in place. Software detects a dead clock when a short run and a long run return the same value.

Top module: `freq_meter`

## Requirements
- R1: After reset the status word reads all zeros.
- R2: A control write with bit 20 clear stops any run in progress. The done flag (status bit 25) reads 0 from the cycle after the write, and the count field (status bits 24:0) keeps its previous value.
- R3: A control write with bit 20 set, with ticks N in bits 19:0 and the reference gate high, sets done exactly 4*N + SETTLE_CYC + 1 bus cycles after the write edge. N = 0 behaves as N = 1.
- R4: While the reference-gate input is low the window does not advance, so done stays 0. The run resumes when the gate returns high.
- R5: The count field holds the number of test-clock edges in the window minus one. For a window of 4*N bus periods and a test period T, that is 4*N*Tbus/T - 1, within 3.
- R6: If the test clock is not toggling, a completed run returns the count from the previous run unchanged, whatever the window length.
- R7: The test counter saturates at all ones in CNT_W bits and does not wrap.
- R8: Control bits 31:21 have no effect, and status bits 31:26 read as zero.
- R9: Once done is set, done and the count field stay unchanged until the next control write.
- R10: A start write made while a run is in progress restarts the window from the newly written tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference tick gate |
| tst_clk | input | 1 | Clock being measured |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control write data: ticks in 19:0, start in 20 |
| status | output | 32 | Done in bit 25, count in bits 24:0 |

## Verification
Done rises exactly 4*N + SETTLE_CYC + 1 cycles after the start-write edge. It falls one cycle after a stop write. The count is loaded on the same edge that raises done. The bench drives its writes on falling edges and reads status on the falling edge after each rising edge. It counts cycles from the write to the first sample that shows done and compares that number with the exact figure. The count is checked against a tolerance that covers the synchronizer delay at each end of the window.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE,
    WIN_RUN,
    WIN_SETTLE,
    WIN_DONE
  } win_state_e;

  localparam int START_BIT = 20;
  localparam int DONE_BIT  = 25;
  localparam int FIELD_W   = 25;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/fm_test_counter.sv
module fm_test_counter #(
  parameter int CNT_W = 25
) (
  input  logic             tst_clk,
  input  logic             tst_rst_n,
  input  logic             gate_async,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             gate_s;
  logic             gate_d_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             open_edge;

  fm_sync #(.W(1)) u_gate_sync (
    .clk  (tst_clk),
    .rst_n(tst_rst_n),
    .d    (gate_async),
    .q    (gate_s)
  );

  assign open_edge = gate_s && !gate_d_q;

  always_comb begin
    cnt_d = cnt_q;
    if (open_edge) begin
      cnt_d = '0;
    end else if (gate_s && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge tst_clk or negedge tst_rst_n) begin
    if (!tst_rst_n) begin
      gate_d_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      gate_d_q <= gate_s;
      cnt_q    <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  assert_no_wrap_R7: assert property (@(posedge tst_clk) disable iff (!tst_rst_n)
    (cnt_q == CNT_MAX && !open_edge) |=> (cnt_q == CNT_MAX));

  assert_unit_step_R5: assert property (@(posedge tst_clk) disable iff (!tst_rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == '0));
endmodule

// File: rtl/fm_window_ctl.sv
module fm_window_ctl
  import fm_pkg::*;
#(
  parameter int TICK_W     = 20,
  parameter int CNT_W      = 25,
  parameter int SETTLE_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              ctl_wr,
  input  logic              ctl_start,
  input  logic [TICK_W-1:0] ctl_ticks,
  input  logic [CNT_W-1:0]  cnt_sync,
  output logic              gate,
  output logic              done,
  output logic [CNT_W-1:0]  cap
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  win_state_e        state_q, state_d;
  logic [TICK_W-1:0] remain_q, remain_d;
  logic [1:0]        div_q, div_d;
  logic [SW-1:0]     settle_q, settle_d;
  logic [CNT_W-1:0]  cap_q;
  logic              gate_q;
  logic              tick;
  logic              cap_en;

  assign tick   = (state_q == WIN_RUN) && ref_en && (div_q == 2'd3);
  assign cap_en = !ctl_wr && (state_q == WIN_SETTLE) && (settle_q == '0);

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    div_d    = div_q;
    settle_d = settle_q;
    if (ctl_wr) begin
      remain_d = ctl_ticks;
      div_d    = 2'd0;
      state_d  = ctl_start ? WIN_RUN : WIN_IDLE;
    end else begin
      case (state_q)
        WIN_RUN: begin
          if (ref_en) div_d = div_q + 2'd1;
          if (tick) begin
            if (remain_q <= TICK_W'(1)) begin
              state_d  = WIN_SETTLE;
              settle_d = SW'(SETTLE_CYC);
            end else begin
              remain_d = remain_q - TICK_W'(1);
            end
          end
        end
        WIN_SETTLE: begin
          if (settle_q == '0) state_d = WIN_DONE;
          else                settle_d = settle_q - SW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WIN_IDLE;
      remain_q <= '0;
      div_q    <= 2'd0;
      settle_q <= '0;
      gate_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      div_q    <= div_d;
      settle_q <= settle_d;
      gate_q   <= (state_d == WIN_RUN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_en) begin
      cap_q <= cnt_sync;
    end
  end

  assign gate = gate_q;
  assign done = (state_q == WIN_DONE);
  assign cap  = cap_q;

  assert_stop_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_start) |=> !done);

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctl_wr) |=> (done && $stable(cap_q)));

  assert_gate_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_RUN && !ref_en && !ctl_wr) |=> ($stable(remain_q) && $stable(div_q) && !done));

  assert_settled_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_SETTLE && $past(state_q) == WIN_SETTLE && settle_q == '0) |-> $stable(cnt_sync));
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int TICK_W     = 20,
  parameter int CNT_W      = 25,
  parameter int SETTLE_CYC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_en,
  input  logic        tst_clk,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] status
);
  logic             tst_rst_n;
  logic             gate;
  logic             done;
  logic [CNT_W-1:0] tst_cnt;
  logic [CNT_W-1:0] cnt_sync;
  logic [CNT_W-1:0] cap;
  logic [FIELD_W-1:0] cnt_field;
  logic             unused_ctl_bits;

  assign unused_ctl_bits = ^ctl_wdata;

  fm_sync #(.W(1)) u_tst_rst_sync (
    .clk  (tst_clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (tst_rst_n)
  );

  fm_test_counter #(.CNT_W(CNT_W)) u_tst_cnt (
    .tst_clk   (tst_clk),
    .tst_rst_n (tst_rst_n),
    .gate_async(gate),
    .cnt       (tst_cnt)
  );

  fm_sync #(.W(CNT_W)) u_cnt_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (tst_cnt),
    .q    (cnt_sync)
  );

  fm_window_ctl #(
    .TICK_W    (TICK_W),
    .CNT_W     (CNT_W),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_en),
    .ctl_wr   (ctl_wr),
    .ctl_start(ctl_wdata[START_BIT]),
    .ctl_ticks(ctl_wdata[TICK_W-1:0]),
    .cnt_sync (cnt_sync),
    .gate     (gate),
    .done     (done),
    .cap      (cap)
  );

  assign cnt_field = FIELD_W'(cap);
  assign status    = {6'b0, done, cnt_field};
endmodule

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;
  localparam int S    = 32;
  localparam int NVEC = 4;
  localparam logic [31:0] VTICKS [NVEC] = '{32'h10, 32'h40, 32'h100, 32'h0};
  localparam int          VPER   [NVEC] = '{8000, 13000, 3000, 8000};

  logic clk = 1'b0;
  logic rst_n;
  logic ref_en;
  logic tst_clk = 1'b0;
  logic tst_run;
  real  half_t = 4.0;
  logic ctl_wr;
  logic [31:0] ctl_wdata;
  logic [31:0] status;
  logic [31:0] status_sat;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  freq_meter #(.SETTLE_CYC(S)) uut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .tst_clk(tst_clk),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .status(status));

  freq_meter #(.SETTLE_CYC(S), .CNT_W(6)) uut_sat (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .tst_clk(tst_clk),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .status(status_sat));

  always #2.5 clk = ~clk;
  always begin
    #(half_t);
    if (tst_run) tst_clk = ~tst_clk;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!status[25] && k < 20000) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k;
    int eff;
    int expc;
    int c1;
    int held;
    rst_n = 1'b0; ref_en = 1'b1; ctl_wr = 1'b0; ctl_wdata = '0; tst_run = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 32'h0, "R1 reset status", status, 0);

    for (int v = 0; v < NVEC; v++) begin
      half_t = VPER[v] / 2000.0;
      wr(VTICKS[v]);
      check(status[25] == 1'b0, "R2 done low after stop", status[25], 0);
      wr(VTICKS[v] | 32'h0010_0000);
      wait_done(k);
      eff = (VTICKS[v] == 0) ? 1 : int'(VTICKS[v]);
      check(k == 4 * eff + S + 1, "R3 done latency", k, 4 * eff + S + 1);
      expc = (20000 * eff) / VPER[v] - 1;
      check((int'(status[24:0]) - expc) <= 3 && (expc - int'(status[24:0])) <= 3,
            "R5 count", status[24:0], expc);
      if (expc > 70)
        check(status_sat[24:0] == 25'd63, "R7 saturation", status_sat[24:0], 63);
    end

    half_t = 4.0;
    wr(32'hFFE0_0010);
    check(status[25] == 1'b0, "R8 stop with high bits", status[25], 0);
    wr(32'hFFF0_0010);
    wait_done(k);
    check(k == 4 * 16 + S + 1, "R8 start with high bits latency", k, 4 * 16 + S + 1);
    check(status[31:26] == 6'd0, "R8 upper status zero", status[31:26], 0);
    c1 = int'(status[24:0]);
    repeat (40) @(negedge clk);
    check(status[25] == 1'b1 && int'(status[24:0]) == c1, "R9 done and count hold", status[24:0], c1);

    tst_run = 1'b0;
    repeat (20) @(negedge clk);
    wr(32'h0000_0010);
    wr(32'h0010_0010);
    wait_done(k);
    check(int'(status[24:0]) == c1, "R6 stale short run", status[24:0], c1);
    wr(32'h0000_0040);
    wr(32'h0010_0040);
    wait_done(k);
    check(int'(status[24:0]) == c1, "R6 stale long run", status[24:0], c1);
    tst_run = 1'b1;

    wr(32'h0010_0100);
    repeat (100) @(negedge clk);
    held = int'(status[24:0]);
    wr(32'h0000_0100);
    check(status[25] == 1'b0 && int'(status[24:0]) == held, "R2 stop mid run", status[24:0], held);
    repeat (1500) @(negedge clk);
    check(status[25] == 1'b0, "R2 stays stopped", status[25], 0);

    wr(32'h0010_0100);
    repeat (200) @(negedge clk);
    wr(32'h0010_0010);
    wait_done(k);
    check(k == 4 * 16 + S + 1, "R10 restart latency", k, 4 * 16 + S + 1);

    ref_en = 1'b0;
    wr(32'h0000_0010);
    wr(32'h0010_0010);
    repeat (300) @(negedge clk);
    check(status[25] == 1'b0, "R4 gate low holds window", status[25], 0);
    ref_en = 1'b1;
    wait_done(k);
    check(status[25] == 1'b1 && k <= 4 * 16 + S + 1, "R4 resumes", k, 4 * 16 + S + 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule